// File: doc/BRIEF.md
# Shared-Bus Register Transfer

This block holds a small set of equal-width registers that exchange data over one common bus. In any clock cycle a single driver places a value on the bus: one of the registers, or an external data input that brings new values into the set. Every register has its own capture enable, and any subset of registers may take the bus value on the same rising edge. This supports a copy from one register to another, a broadcast of one value into several registers, and loading from outside.

A single bus can carry only one value per cycle. When more than one driver is enabled, the block refuses the whole request and raises a conflict flag. This covers a swap of two registers, which needs both of them to drive at once. When a capture is requested with no driver enabled, the bus reads as zero and a separate flag reports the missing driver.

The bus source can be built as an AND-OR structure, the logic equivalent of enabled bus drivers, or as an indexed multiplexer. A parameter picks one, and both give the same register behaviour.

Top module: `sharedBusXfer`

## Requirements
- R1: A synchronous reset, sampled at a rising edge, clears every register, `conflictFlag` and `noDriverFlag` to zero.
- R2: With exactly one driver enabled, each register whose `loadEn` bit is set holds the bus value after the next rising edge. The driver is register i when `srcEn[i]` is set, or `extData` when `extEn` is set. Register i is read at `regsOut[i*WIDTH +: WIDTH]`.
- R3: A register whose `loadEn` bit is clear keeps its value across the edge, whatever the other inputs are.
- R4: Broadcast: with one driver and several `loadEn` bits set, every selected register takes the same driver value on the same edge.
- R5: A register that is both the driver and a destination keeps its own value. Other destinations in that cycle receive the value it held before the edge.
- R6: When two or more of the drivers (`srcEn` bits and `extEn`) are set, no register changes and `conflictFlag` is 1 after that edge. A swap request such as `srcEn`=3'b011 with `loadEn`=3'b011 falls in this case.
- R7: With no driver enabled, every register whose `loadEn` bit is set becomes zero and `noDriverFlag` is 1 after that edge. With no driver and no load, nothing changes and the flag stays 0.
- R8: `BUS_STYLE` 0 (AND-OR drivers) and `BUS_STYLE` 1 (indexed multiplexer) produce identical register contents and flags for every input sequence.
- R9: Each flag describes only the request taken at the most recent edge. After a request with exactly one driver, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| srcEn | input | NUM_REGS | Per-register enable to drive the bus |
| extEn | input | 1 | Enable for the external data input to drive the bus |
| extData | input | WIDTH | External value placed on the bus when `extEn` is set |
| loadEn | input | NUM_REGS | Per-register capture enable |
| regsOut | output | NUM_REGS*WIDTH | Register contents, register i in slice i |
| conflictFlag | output | 1 | More than one driver was enabled at the last edge |
| noDriverFlag | output | 1 | A load was requested at the last edge with no driver |

## Verification
Every result belongs to the rising edge that samples the request: register contents and both flags change right after that edge and hold for exactly one cycle. The bench drives each request on a falling edge and compares all registers and both flags at the next falling edge, half a period after the capturing edge and before any further input change. Before each of the 128 combinations of driver and load enables, distinct values are loaded into the registers. The expected contents are therefore taken from the pre-edge values, which exposes any capture of a value already updated in the same cycle. A multiplexer-style copy runs in lockstep with the AND-OR instance, and its outputs are compared on the same falling edge.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  localparam int SBX_MAX_REGS = 8;
  localparam int SBX_IDX_W = $clog2(SBX_MAX_REGS);

  typedef struct packed {
    logic [SBX_MAX_REGS-1:0] loadMask;
    logic [SBX_MAX_REGS-1:0] regDrive;
    logic                    extDrive;
    logic                    busZero;
    logic [SBX_IDX_W-1:0]    regIdx;
  } sbx_strobe_t;
endpackage

// File: rtl/sbxControl.sv
module sbxControl
  import sbx_pkg::*;
#(
  parameter int NUM_REGS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REGS-1:0] srcEn,
  input  logic                extEn,
  input  logic [NUM_REGS-1:0] loadEn,
  output sbx_strobe_t         strobes,
  output logic                conflictFlag,
  output logic                noDriverFlag
);
  int   drvCount;
  logic multiDrive;
  logic noDrive;

  always_comb begin
    drvCount = extEn ? 1 : 0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (srcEn[i]) drvCount = drvCount + 1;
    end
    multiDrive = (drvCount > 1);
    noDrive    = (drvCount == 0);
  end

  always_comb begin
    strobes          = '0;
    strobes.extDrive = extEn;
    strobes.busZero  = noDrive || multiDrive;
    for (int i = 0; i < NUM_REGS; i++) begin
      strobes.regDrive[i] = srcEn[i];
      strobes.loadMask[i] = loadEn[i] && !multiDrive;
      if (srcEn[i]) strobes.regIdx = SBX_IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conflictFlag <= 1'b0;
      noDriverFlag <= 1'b0;
    end else begin
      conflictFlag <= multiDrive;
      noDriverFlag <= noDrive && (|loadEn);
    end
  end

  assert_conflict_flag_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones({extEn, srcEn}) > 1) |=> conflictFlag);

  assert_nodriver_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (({extEn, srcEn} == '0) && (|loadEn)) |=> noDriverFlag);

  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot({extEn, srcEn}) |=> (!conflictFlag && !noDriverFlag));

  assert_flags_reset_R1: assert property (@(posedge clk)
    rst |=> (!conflictFlag && !noDriverFlag));
endmodule

// File: rtl/sbxDatapath.sv
module sbxDatapath
  import sbx_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int NUM_REGS  = 3,
  parameter int BUS_STYLE = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  sbx_strobe_t               strobes,
  input  logic [WIDTH-1:0]          extData,
  output logic [NUM_REGS*WIDTH-1:0] regsOut
);
  logic [WIDTH-1:0] regQ [NUM_REGS];
  logic [WIDTH-1:0] busValue;

  generate
    if (BUS_STYLE == 0) begin : g_andOr
      always_comb begin
        busValue = strobes.extDrive ? extData : '0;
        for (int i = 0; i < NUM_REGS; i++) begin
          if (strobes.regDrive[i]) busValue = busValue | regQ[i];
        end
      end
    end else begin : g_mux
      always_comb begin
        busValue = '0;
        if (!strobes.busZero) begin
          if (strobes.extDrive) begin
            busValue = extData;
          end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
              if (strobes.regIdx == SBX_IDX_W'(i)) busValue = regQ[i];
            end
          end
        end
      end
    end
  endgenerate

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regQ[i] <= '0;
      else if (strobes.loadMask[i]) regQ[i] <= busValue;
    end
    assign regsOut[i*WIDTH +: WIDTH] = regQ[i];

    assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (regQ[i] == '0));

    assert_hold_unloaded_R3: assert property (@(posedge clk) disable iff (rst)
      !strobes.loadMask[i] |=> $stable(regQ[i]));

    assert_ext_load_R2: assert property (@(posedge clk) disable iff (rst)
      (strobes.loadMask[i] && strobes.extDrive &&
       (strobes.regDrive[NUM_REGS-1:0] == '0)) |=> (regQ[i] == $past(extData)));

    assert_zero_load_R7: assert property (@(posedge clk) disable iff (rst)
      (strobes.loadMask[i] && !strobes.extDrive &&
       (strobes.regDrive[NUM_REGS-1:0] == '0)) |=> (regQ[i] == '0));

    for (genvar j = 0; j < NUM_REGS; j++) begin : g_src
      assert_reg_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (strobes.loadMask[i] && !strobes.extDrive && strobes.regDrive[j] &&
         $onehot(strobes.regDrive[NUM_REGS-1:0])) |=> (regQ[i] == $past(regQ[j])));
    end
  end
endmodule

// File: rtl/sharedBusXfer.sv
module sharedBusXfer
  import sbx_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int NUM_REGS  = 3,
  parameter int BUS_STYLE = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_REGS-1:0]       srcEn,
  input  logic                      extEn,
  input  logic [WIDTH-1:0]          extData,
  input  logic [NUM_REGS-1:0]       loadEn,
  output logic [NUM_REGS*WIDTH-1:0] regsOut,
  output logic                      conflictFlag,
  output logic                      noDriverFlag
);
  sbx_strobe_t strobes;

  sbxControl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rst(rst), .srcEn(srcEn), .extEn(extEn), .loadEn(loadEn),
    .strobes(strobes), .conflictFlag(conflictFlag), .noDriverFlag(noDriverFlag)
  );

  sbxDatapath #(.WIDTH(WIDTH), .NUM_REGS(NUM_REGS), .BUS_STYLE(BUS_STYLE)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .extData(extData), .regsOut(regsOut)
  );

  assert_conflict_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones({extEn, srcEn}) > 1) |=> $stable(regsOut));
endmodule

// File: tb/sim_sharedBusXfer.sv
module sim_sharedBusXfer;
  localparam int W = 8;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] srcEn = '0;
  logic extEn = 1'b0;
  logic [W-1:0] extData = '0;
  logic [N-1:0] loadEn = '0;
  logic [N*W-1:0] regsA, regsB;
  logic confA, confB, nodA, nodB;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] mdl [N];
  logic expConf, expNod;

  always #2 clk = ~clk;

  sharedBusXfer #(.WIDTH(W), .NUM_REGS(N), .BUS_STYLE(0)) u0 (
    .clk(clk), .rst(rst), .srcEn(srcEn), .extEn(extEn), .extData(extData),
    .loadEn(loadEn), .regsOut(regsA), .conflictFlag(confA), .noDriverFlag(nodA));

  sharedBusXfer #(.WIDTH(W), .NUM_REGS(N), .BUS_STYLE(1)) u1 (
    .clk(clk), .rst(rst), .srcEn(srcEn), .extEn(extEn), .extData(extData),
    .loadEn(loadEn), .regsOut(regsB), .conflictFlag(confB), .noDriverFlag(nodB));

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic checkState(string regTag, string flagTag, logic [N-1:0] ld);
    for (int i = 0; i < N; i++) begin
      check(ld[i] ? regTag : "R3", $sformatf("reg%0d", i), 32'(regsA[i*W +: W]), 32'(mdl[i]));
      check("R8", $sformatf("mux reg%0d", i), 32'(regsB[i*W +: W]), 32'(regsA[i*W +: W]));
    end
    check(flagTag, "conflictFlag", 32'(confA), 32'(expConf));
    check(flagTag, "noDriverFlag", 32'(nodA), 32'(expNod));
    check("R8", "mux flags", 32'({confB, nodB}), 32'({confA, nodA}));
  endtask

  // Drive at a falling edge, let the rising edge capture, check at the next falling edge.
  task automatic step(logic [N-1:0] s, logic e, logic [W-1:0] d, logic [N-1:0] ld);
    logic [W-1:0] old [N];
    logic [W-1:0] val;
    int drivers;
    string regTag, flagTag;
    srcEn = s; extEn = e; extData = d; loadEn = ld;
    for (int i = 0; i < N; i++) old[i] = mdl[i];
    drivers = $countones({e, s});
    val = '0;
    if (e) val = d;
    for (int i = 0; i < N; i++) if (s[i]) val = old[i];
    expConf = (drivers > 1);
    expNod = (drivers == 0) && (|ld);
    if (drivers > 1) begin
      regTag = "R6"; flagTag = "R6";
    end else if (drivers == 0) begin
      regTag = "R7"; flagTag = "R7";
      for (int i = 0; i < N; i++) if (ld[i]) mdl[i] = '0;
    end else begin
      flagTag = "R9";
      regTag = ((s & ld) != '0) ? "R5" : ($countones(ld) > 1 ? "R4" : "R2");
      for (int i = 0; i < N; i++) if (ld[i]) mdl[i] = val;
    end
    @(negedge clk);
    checkState(regTag, flagTag, ld);
  endtask

  task automatic preload(int seed);
    for (int i = 0; i < N; i++)
      step('0, 1'b1, W'(seed * 7 + i * 49 + 1), N'(1 << i));
  endtask

  task automatic doReset();
    rst = 1'b1;
    srcEn = '0; extEn = 1'b0; loadEn = '0;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    expConf = 1'b0; expNod = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    checkState("R1", "R1", {N{1'b1}});
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();

    // Exhaustive sweep of drivers and loads from distinct preloaded values.
    for (int c = 0; c < 128; c++) begin
      preload(c);
      step(N'(c & 7), c[3], W'(c * 13 + 5), N'((c >> 4) & 7));
    end

    // Swap request R0<->R1 is refused (R6).
    preload(200);
    step(3'b011, 1'b0, '0, 3'b011);
    // Clean copy afterwards clears the flag (R9).
    step(3'b100, 1'b0, '0, 3'b001);
    // Broadcast R1 into R0 and R2 (R4).
    step(3'b010, 1'b0, '0, 3'b101);
    // External driver alongside a register is a conflict (R6).
    step(3'b001, 1'b1, 8'hA5, 3'b111);
    // No driver, no load: nothing changes, no flag (R7).
    step(3'b000, 1'b0, 8'h3C, 3'b000);

    // Reset in mid-run clears loaded state and a raised flag (R1).
    preload(77);
    step(3'b110, 1'b0, '0, 3'b001);
    doReset();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule